// File: doc/BRIEF.md
# Two-Write Two-Read XOR-Encoded Memory

This block is a memory with two independent write ports (A and B) and two independent read ports, built only from simple banks that each offer one write port and one synchronous read port. Each write port owns a group of banks. A word written through one port is not stored as is. It is stored XOR-combined with the current content of the same address in the other port's group. A read XORs one bank of each group at the same address, which returns the last value written by either port.

Every write takes two clock edges. At the first edge the request is captured and the other group's word at that address is read. At the second edge the encoded word is written into every bank of the writer's group. Each group has one bank that serves the other port's encode read, plus one bank for each read port. With two writers and two readers this makes six banks. Back-to-back writes from different ports to one address are handled by forwarding the value that is being committed. When both ports write the same address in the same cycle, port B wins.

Top module: `xor_multiport_mem`

## Requirements
- R1: After synchronous reset every address reads as zero on both read ports.
- R2: A read address applied at a rising edge produces its data on the read data port directly after that edge, so one read result is available every cycle.
- R3: A write through port A at a rising edge can be read on both read ports from an address applied two or more edges later.
- R4: A write through port B behaves the same as R3, including when it overwrites an address that port A wrote earlier.
- R5: When the two ports write the same address in consecutive cycles, in either order, the later write is the value read afterwards.
- R6: When both write ports write the same address in the same cycle, the value read afterwards is port B's data. A later write by port A to that address is then read back correctly.
- R7: A read whose address is applied at the edge directly after a write request to that address returns the value from before the write.
- R8: Writes by both ports to different addresses in the same cycle are both kept.
- R9: When both read ports use the same address, they return identical data.
- R10: A write port whose enable is low changes no stored word, whatever its address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears every bank |
| wa_en | input | 1 | Write port A request enable |
| wa_addr | input | $clog2(DEPTH) | Write port A address |
| wa_data | input | DW | Write port A data |
| wb_en | input | 1 | Write port B request enable; wins on a same-address collision |
| wb_addr | input | $clog2(DEPTH) | Write port B address |
| wb_data | input | DW | Write port B data |
| rd0_addr | input | $clog2(DEPTH) | Read port 0 address |
| rd0_data | output | DW | Read port 0 decoded data, one edge after the address |
| rd1_addr | input | $clog2(DEPTH) | Read port 1 address |
| rd1_data | output | DW | Read port 1 decoded data, one edge after the address |

## Verification
Assertions check on every cycle that a write request is committed at exactly the next edge with its own address, that a same-address collision commits zero to group A and B's raw data to group B, and that both read ports agree whenever they read one address, which shows that the group replicas stay identical. Whether the XOR decode really returns the last written value can only be shown by the bench's scenarios. These cover forwarding between back-to-back writes of the two ports, the read-old timing of a read next to a write, the state after a collision, and disabled writes. They compare the read data against a reference array that the bench keeps itself.

// File: rtl/xmp_pkg.sv
package xmp_pkg;
  localparam int XMP_WR_PORTS = 2;
  localparam int XMP_RD_PORTS = 2;

  // banks needed for m writers and n readers with XOR encoding
  function automatic int xmp_bank_count(input int m, input int n);
    return m * (m - 1 + n);
  endfunction
endpackage

// File: rtl/xmp_bank.sv
module xmp_bank #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // read-first: a read at the edge of a write returns the earlier word
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/xmp_wr_stage.sv
module xmp_wr_stage #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_en,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          req_zero,   // collision loser: clear own group
  input  logic          req_raw,    // collision winner: store data unencoded
  input  logic [DW-1:0] old_q,      // other group's word, read at request edge
  input  logic          peer_en,    // other group's commit in this cycle
  input  logic [AW-1:0] peer_addr,
  input  logic [DW-1:0] peer_val,
  output logic          cm_en,
  output logic [AW-1:0] cm_addr,
  output logic [DW-1:0] cm_val
);
  logic [DW-1:0] data_q;
  logic          zero_q, raw_q, fwd_hit_q;
  logic [DW-1:0] fwd_val_q;
  logic [DW-1:0] other_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      cm_en     <= 1'b0;
      cm_addr   <= '0;
      data_q    <= '0;
      zero_q    <= 1'b0;
      raw_q     <= 1'b0;
      fwd_hit_q <= 1'b0;
      fwd_val_q <= '0;
    end else begin
      cm_en     <= req_en;
      cm_addr   <= req_addr;
      data_q    <= req_data;
      zero_q    <= req_zero;
      raw_q     <= req_raw;
      // the peer writes its group at this very edge; the bank read misses it
      fwd_hit_q <= peer_en && (peer_addr == req_addr);
      fwd_val_q <= peer_val;
    end
  end

  assign other_word = fwd_hit_q ? fwd_val_q : old_q;

  always_comb begin
    if (zero_q)     cm_val = '0;
    else if (raw_q) cm_val = data_q;
    else            cm_val = data_q ^ other_word;
  end

  assert_commit_next_edge_R3: assert property (@(posedge clk) disable iff (rst)
    req_en |=> (cm_en && cm_addr == $past(req_addr)));

  assert_loser_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (req_en && req_zero) |=> (cm_val == '0));
endmodule

// File: rtl/xor_multiport_mem.sv
module xor_multiport_mem #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wa_en,
  input  logic [AW-1:0] wa_addr,
  input  logic [DW-1:0] wa_data,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_addr,
  input  logic [DW-1:0] wb_data,
  input  logic [AW-1:0] rd0_addr,
  output logic [DW-1:0] rd0_data,
  input  logic [AW-1:0] rd1_addr,
  output logic [DW-1:0] rd1_data
);
  import xmp_pkg::*;

  localparam int NRD = XMP_RD_PORTS;
  localparam int NGR = XMP_WR_PORTS;
  localparam int BPG = xmp_bank_count(NGR, NRD) / NGR;  // banks per group

  logic [AW-1:0] rd_addr [NRD];
  logic [DW-1:0] rd_word [NRD];
  logic [DW-1:0] bank_q  [NGR][BPG];

  logic          cm_en   [NGR];
  logic [AW-1:0] cm_addr [NGR];
  logic [DW-1:0] cm_val  [NGR];
  logic [AW-1:0] enc_raddr [NGR];

  logic coll;

  assign rd_addr[0] = rd0_addr;
  assign rd_addr[1] = rd1_addr;
  assign rd0_data   = rd_word[0];
  assign rd1_data   = rd_word[1];

  // same address in the same cycle: group B wins
  assign coll = wa_en && wb_en && (wa_addr == wb_addr);

  // bank 0 of a group feeds the other port's encode read
  assign enc_raddr[0] = wb_addr;
  assign enc_raddr[1] = wa_addr;

  xmp_wr_stage #(.DW(DW), .DEPTH(DEPTH)) u_wr_a (
    .clk, .rst,
    .req_en(wa_en), .req_addr(wa_addr), .req_data(wa_data),
    .req_zero(coll), .req_raw(1'b0),
    .old_q(bank_q[1][0]),
    .peer_en(cm_en[1]), .peer_addr(cm_addr[1]), .peer_val(cm_val[1]),
    .cm_en(cm_en[0]), .cm_addr(cm_addr[0]), .cm_val(cm_val[0])
  );

  xmp_wr_stage #(.DW(DW), .DEPTH(DEPTH)) u_wr_b (
    .clk, .rst,
    .req_en(wb_en), .req_addr(wb_addr), .req_data(wb_data),
    .req_zero(1'b0), .req_raw(coll),
    .old_q(bank_q[0][0]),
    .peer_en(cm_en[0]), .peer_addr(cm_addr[0]), .peer_val(cm_val[0]),
    .cm_en(cm_en[1]), .cm_addr(cm_addr[1]), .cm_val(cm_val[1])
  );

  for (genvar g = 0; g < NGR; g++) begin : g_grp
    for (genvar j = 0; j < BPG; j++) begin : g_bank
      logic [AW-1:0] ra;
      if (j == 0) begin : g_enc
        assign ra = enc_raddr[g];
      end else begin : g_rd
        assign ra = rd_addr[j-1];
      end
      xmp_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
        .clk, .rst,
        .we(cm_en[g]), .waddr(cm_addr[g]), .wdata(cm_val[g]),
        .raddr(ra), .rdata(bank_q[g][j])
      );
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_dec
    assign rd_word[r] = bank_q[0][r+1] ^ bank_q[1][r+1];
  end

  assert_b_commit_R4: assert property (@(posedge clk) disable iff (rst)
    wb_en |=> (cm_en[1] && cm_addr[1] == $past(wb_addr)));

  assert_collision_b_raw_R6: assert property (@(posedge clk) disable iff (rst)
    coll |=> (cm_val[1] == $past(wb_data)));

  assert_replicas_agree_R9: assert property (@(posedge clk) disable iff (rst)
    (rd0_addr == rd1_addr) |=> (rd0_data == rd1_data));
endmodule

// File: tb/tb_xor_multiport_mem.sv
module tb_xor_multiport_mem;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst;
  logic          wa_en, wb_en;
  logic [AW-1:0] wa_addr, wb_addr, rd0_addr, rd1_addr;
  logic [DW-1:0] wa_data, wb_data, rd0_data, rd1_data;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] ref_m [DEPTH];

  always #2.5 clk = ~clk;

  xor_multiport_mem #(.DW(DW), .DEPTH(DEPTH)) dut (
    .clk, .rst,
    .wa_en, .wa_addr, .wa_data,
    .wb_en, .wb_addr, .wb_data,
    .rd0_addr, .rd0_data, .rd1_addr, .rd1_data
  );

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // apply inputs after a falling edge, return after the next falling edge
  task automatic drive(input logic ae, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                       input logic be, input logic [AW-1:0] ba, input logic [DW-1:0] bd,
                       input logic [AW-1:0] r0, input logic [AW-1:0] r1);
    wa_en = ae; wa_addr = aa; wa_data = ad;
    wb_en = be; wb_addr = ba; wb_data = bd;
    rd0_addr = r0; rd1_addr = r1;
    @(negedge clk);
    wa_en = 1'b0; wb_en = 1'b0;
  endtask

  task automatic idle();
    drive(1'b0, '0, '0, 1'b0, '0, '0, rd0_addr, rd1_addr);
  endtask

  task automatic rd_pair(input string req, input logic [AW-1:0] a0, input logic [AW-1:0] a1);
    drive(1'b0, '0, '0, 1'b0, '0, '0, a0, a1);
    chk(req, rd0_data, ref_m[a0]);
    chk(req, rd1_data, ref_m[a1]);
  endtask

  task automatic t_reset();   // R1
    for (int i = 0; i < DEPTH; i++) rd_pair("R1", AW'(i), AW'(DEPTH-1-i));
  endtask

  task automatic t_write_a(); // R3, R9
    drive(1'b1, 4'd3, 16'hA5A5, 1'b0, '0, '0, '0, '0);
    ref_m[3] = 16'hA5A5;
    idle();
    rd_pair("R3", 4'd3, 4'd3);
    chk("R9", rd0_data, rd1_data);
  endtask

  task automatic t_write_b(); // R4
    drive(1'b0, '0, '0, 1'b1, 4'd5, 16'h1234, '0, '0);
    ref_m[5] = 16'h1234;
    idle();
    rd_pair("R4", 4'd5, 4'd3);
    drive(1'b0, '0, '0, 1'b1, 4'd3, 16'h0F0F, '0, '0);
    ref_m[3] = 16'h0F0F;
    idle();
    rd_pair("R4", 4'd3, 4'd5);
  endtask

  task automatic t_latency(); // R2
    rd_pair("R2", 4'd3, 4'd5);
    rd_pair("R2", 4'd5, 4'd3);
    rd_pair("R2", 4'd0, 4'd5);
  endtask

  task automatic t_read_old(); // R7
    drive(1'b1, 4'd7, 16'hBEEF, 1'b0, '0, '0, '0, '0);
    rd_pair("R7", 4'd7, 4'd7);   // reads at the commit edge: still old
    ref_m[7] = 16'hBEEF;
    rd_pair("R7", 4'd7, 4'd0);
  endtask

  task automatic t_back_to_back(); // R5
    drive(1'b1, 4'd9, 16'h1357, 1'b0, '0, '0, '0, '0);
    drive(1'b0, '0, '0, 1'b1, 4'd9, 16'h2468, '0, '0);
    ref_m[9] = 16'h2468;
    idle();
    rd_pair("R5", 4'd9, 4'd9);
    drive(1'b0, '0, '0, 1'b1, 4'd10, 16'hCAFE, '0, '0);
    drive(1'b1, 4'd10, 16'h7788, 1'b0, '0, '0, '0, '0);
    ref_m[10] = 16'h7788;
    idle();
    rd_pair("R5", 4'd10, 4'd9);
  endtask

  task automatic t_collision(); // R6
    drive(1'b1, 4'd11, 16'h1111, 1'b1, 4'd11, 16'h2222, '0, '0);
    ref_m[11] = 16'h2222;
    idle();
    rd_pair("R6", 4'd11, 4'd11);
    drive(1'b1, 4'd11, 16'h3333, 1'b0, '0, '0, '0, '0);
    ref_m[11] = 16'h3333;
    idle();
    rd_pair("R6", 4'd11, 4'd11);
  endtask

  task automatic t_dual(); // R8
    drive(1'b1, 4'd12, 16'h5A5A, 1'b1, 4'd13, 16'hC3C3, '0, '0);
    ref_m[12] = 16'h5A5A;
    ref_m[13] = 16'hC3C3;
    idle();
    rd_pair("R8", 4'd12, 4'd13);
  endtask

  task automatic t_ignore(); // R10
    wa_addr = 4'd3; wa_data = 16'hDEAD;
    wb_addr = 4'd5; wb_data = 16'hBEEF;
    rd0_addr = '0; rd1_addr = '0;
    @(negedge clk);
    @(negedge clk);
    rd_pair("R10", 4'd3, 4'd5);
  endtask

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog got=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_m[i] = '0;
    rst = 1'b1;
    wa_en = 1'b0; wa_addr = '0; wa_data = '0;
    wb_en = 1'b0; wb_addr = '0; wb_data = '0;
    rd0_addr = '0; rd1_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_a();
    t_write_b();
    t_latency();
    t_read_old();
    t_back_to_back();
    t_collision();
    t_dual();
    t_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule